// File: doc/BRIEF.md
# Working Register File with Pointer Pair

This block holds the thirty-two 8-bit working registers of a small 8-bit RISC core. Two read ports give the ALU both register operands in the same cycle. Each read port takes a full 5-bit selector and returns the word combinationally. A separate read port takes a 4-bit selector for instructions that carry an immediate constant. That selector can only reach the upper sixteen registers, so a lower register cannot be encoded at all.

The two highest registers also form a 16-bit pointer. Register 30 is the low byte and register 31 the high byte. The pointer is driven onto an output at all times for program-memory fetches. The file also uses it to address itself: an indirect read port returns the register that the low five bits of register 30 name, and the write port can send its data to that same register. In both cases the high byte and the top three bits of register 30 play no part.

There is one write port, and the 2-bit source code picks how its target is found. Writes take effect on the rising clock edge. Every read shows the value held before that edge. All ports are plain level signals with no valid/ready handshake: a register file answers every cycle and never applies back-pressure.

Top module: `wreg_file`

## Requirements
- R1: A synchronous reset (rst high at a rising edge) clears all 32 registers to 0x00, so every read port and ptr_out read zero afterwards.
- R2: rd_a_data and rd_b_data show the registers named by rd_a_sel and rd_b_sel (any of 0..31) in the same cycle. This holds for every pair of selectors, including the case where both name the same register.
- R3: With wr_src = 2'b01 (immediate form), a write lands in register 16 + wr_sel[3:0]. wr_sel[4] is ignored, and registers 0 to 15 are never changed.
- R4: imm_rd_data shows register 16 + imm_sel for every value of the 4-bit imm_sel.
- R5: ptr_out equals {register 31, register 30} at all times. Bits 7:0 come from register 30. A write to either register appears on ptr_out after the edge that performs it.
- R6: ind_rd_data shows the register named by bits 4:0 of register 30. Register 31 and bits 7:5 of register 30 have no effect on which register is read.
- R7: With wr_src = 2'b10 (indirect), a write goes to the register named by register 30 bits 4:0 as they stood before the edge. This includes the case where register 30 names itself.
- R8: With wr_src = 2'b00, a write goes to register wr_sel on the rising edge when wr_en is high. When wr_en is low, or when wr_src = 2'b11, no register changes.
- R9: There is no write-through. During the cycle that a write is presented, every read port still shows the register's old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| rd_a_sel | input | 5 | First operand register number |
| rd_a_data | output | 8 | First operand value |
| rd_b_sel | input | 5 | Second operand register number |
| rd_b_data | output | 8 | Second operand value |
| imm_sel | input | 4 | Immediate-form register field (register 16 + field) |
| imm_rd_data | output | 8 | Value of the immediate-form register |
| ind_rd_data | output | 8 | Value of the register named by register 30 bits 4:0 |
| wr_en | input | 1 | Write enable |
| wr_src | input | 2 | Write target source: 00 direct, 01 immediate, 10 indirect, 11 none |
| wr_sel | input | 5 | Write register number (low 4 bits only in immediate form) |
| wr_data | input | 8 | Write data |
| ptr_out | output | 16 | Pointer {register 31, register 30} |

## Verification
A wrong register state shows on the read ports in the same cycle that a selector names the damaged register. The bench therefore sweeps every selector pair after each batch of writes. A mapping fault in the immediate or indirect path corrupts some other register. The bench finds that corruption on the next full sweep, one or two cycles after the faulty write. An indirect write aimed at the wrong target shows at once on ptr_out or on ind_rd_data after the edge.

// File: rtl/wrf_pkg.sv
package wrf_pkg;
  typedef enum logic [1:0] {
    WSRC_DIRECT = 2'b00,
    WSRC_IMM    = 2'b01,
    WSRC_PTR    = 2'b10,
    WSRC_NONE   = 2'b11
  } wsrc_e;
endpackage

// File: rtl/wrf_sel_map.sv
// Turns the immediate field, the pointer and the write source into full register numbers.
module wrf_sel_map
  import wrf_pkg::*;
#(
  parameter int NREG  = 32,
  parameter int AW    = $clog2(NREG),
  parameter int IMM_W = AW - 1
) (
  input  logic             wr_en,
  input  logic [1:0]       wr_src,
  input  logic [AW-1:0]    wr_sel,
  input  logic [IMM_W-1:0] imm_sel,
  input  logic [AW-1:0]    ptr_idx,
  output logic [AW-1:0]    imm_addr,
  output logic [AW-1:0]    wr_addr,
  output logic             wr_go
);
  localparam logic [AW-1:0] IMM_BASE = AW'(NREG / 2);

  always_comb begin
    imm_addr = IMM_BASE | AW'(imm_sel);
    wr_go    = wr_en && (wsrc_e'(wr_src) != WSRC_NONE);
    unique case (wsrc_e'(wr_src))
      WSRC_IMM:    wr_addr = IMM_BASE | AW'(wr_sel[IMM_W-1:0]);
      WSRC_PTR:    wr_addr = ptr_idx;
      default:     wr_addr = wr_sel;
    endcase
  end
endmodule

// File: rtl/wrf_bank.sv
// Storage array with a single synchronous write port and synchronous clear.
module wrf_bank #(
  parameter int DW   = 8,
  parameter int NREG = 32,
  parameter int AW   = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_go,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] regs [NREG]
);
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (wr_go) begin
      regs[wr_addr] <= wr_data;
    end
  end

  // R8: a performed write is visible in the addressed word one edge later
  assert_write_lands_R8: assert property (@(posedge clk) disable iff (rst)
    wr_go |=> regs[$past(wr_addr)] == $past(wr_data));

  // R1: reset leaves the lowest and highest words cleared
  assert_reset_clears_R1: assert property (@(posedge clk)
    rst |=> (regs[0] == '0 && regs[NREG-1] == '0));
endmodule

// File: rtl/wrf_read_port.sv
// One combinational read port into the storage array.
module wrf_read_port #(
  parameter int DW   = 8,
  parameter int NREG = 32,
  parameter int AW   = $clog2(NREG)
) (
  input  logic [DW-1:0] regs [NREG],
  input  logic [AW-1:0] addr,
  output logic [DW-1:0] data
);
  always_comb data = regs[addr];
endmodule

// File: rtl/wreg_file.sv
module wreg_file
  import wrf_pkg::*;
#(
  parameter int DW   = 8,
  parameter int NREG = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [4:0]        rd_a_sel,
  output logic [DW-1:0]     rd_a_data,
  input  logic [4:0]        rd_b_sel,
  output logic [DW-1:0]     rd_b_data,
  input  logic [3:0]        imm_sel,
  output logic [DW-1:0]     imm_rd_data,
  output logic [DW-1:0]     ind_rd_data,
  input  logic              wr_en,
  input  logic [1:0]        wr_src,
  input  logic [4:0]        wr_sel,
  input  logic [DW-1:0]     wr_data,
  output logic [2*DW-1:0]   ptr_out
);
  localparam int AW     = $clog2(NREG);
  localparam int IMM_W  = AW - 1;
  localparam int PTR_LO = NREG - 2;
  localparam int PTR_HI = NREG - 1;
  localparam int NPORT  = 4;

  logic [DW-1:0] regs [NREG];
  logic [AW-1:0] imm_addr, wr_addr;
  logic          wr_go;
  logic [AW-1:0] rp_addr [NPORT];
  logic [DW-1:0] rp_data [NPORT];

  wrf_sel_map #(.NREG(NREG), .AW(AW), .IMM_W(IMM_W)) i_map (
    .wr_en   (wr_en),
    .wr_src  (wr_src),
    .wr_sel  (wr_sel),
    .imm_sel (imm_sel),
    .ptr_idx (regs[PTR_LO][AW-1:0]),
    .imm_addr(imm_addr),
    .wr_addr (wr_addr),
    .wr_go   (wr_go)
  );

  wrf_bank #(.DW(DW), .NREG(NREG), .AW(AW)) i_bank (
    .clk    (clk),
    .rst    (rst),
    .wr_go  (wr_go),
    .wr_addr(wr_addr),
    .wr_data(wr_data),
    .regs   (regs)
  );

  always_comb begin
    rp_addr[0] = rd_a_sel;
    rp_addr[1] = rd_b_sel;
    rp_addr[2] = imm_addr;
    rp_addr[3] = regs[PTR_LO][AW-1:0];
  end

  for (genvar p = 0; p < NPORT; p++) begin : g_rport
    wrf_read_port #(.DW(DW), .NREG(NREG), .AW(AW)) i_rp (
      .regs(regs),
      .addr(rp_addr[p]),
      .data(rp_data[p])
    );
  end

  assign rd_a_data   = rp_data[0];
  assign rd_b_data   = rp_data[1];
  assign imm_rd_data = rp_data[2];
  assign ind_rd_data = rp_data[3];
  assign ptr_out     = {regs[PTR_HI], regs[PTR_LO]};

  // R3: immediate-form writes only ever target the upper half
  assert_imm_upper_R3: assert property (@(posedge clk) disable iff (rst)
    (wr_go && wsrc_e'(wr_src) == WSRC_IMM) |-> wr_addr >= AW'(NREG / 2));

  // R5: a write to the low pointer byte shows on ptr_out after the edge
  assert_ptr_follows_R5: assert property (@(posedge clk) disable iff (rst)
    (wr_go && wr_addr == AW'(PTR_LO)) |=> ptr_out[DW-1:0] == $past(wr_data));

  // R9: without a write, an unchanged selector keeps an unchanged operand
  assert_no_bypass_R9: assert property (@(posedge clk) disable iff (rst)
    !wr_go |=> (!$stable(rd_a_sel) || $stable(rd_a_data)));

  // R6: indirect data only moves when the pointer index or the file is written
  assert_ind_steady_R6: assert property (@(posedge clk) disable iff (rst)
    !wr_go |=> (!$stable(ptr_out[AW-1:0]) || $stable(ind_rd_data)));
endmodule

// File: tb/test_wreg_file.sv
module test_wreg_file;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [4:0] rd_a_sel = '0, rd_b_sel = '0, wr_sel = '0;
  logic [3:0] imm_sel = '0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_src = 2'b00;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_a_data, rd_b_data, imm_rd_data, ind_rd_data;
  logic [15:0] ptr_out;

  int checks = 0, fails = 0;
  logic [7:0] mdl [32];
  bit done = 0;

  always #5 clk = ~clk;

  wreg_file i_wreg_file (
    .clk(clk), .rst(rst),
    .rd_a_sel(rd_a_sel), .rd_a_data(rd_a_data),
    .rd_b_sel(rd_b_sel), .rd_b_data(rd_b_data),
    .imm_sel(imm_sel), .imm_rd_data(imm_rd_data),
    .ind_rd_data(ind_rd_data),
    .wr_en(wr_en), .wr_src(wr_src), .wr_sel(wr_sel), .wr_data(wr_data),
    .ptr_out(ptr_out)
  );

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] src, logic [4:0] sel, logic [7:0] d);
    int tgt;
    @(negedge clk);
    wr_en = 1'b1; wr_src = src; wr_sel = sel; wr_data = d;
    case (src)
      2'b00: tgt = int'(sel);
      2'b01: tgt = 16 + int'(sel[3:0]);
      2'b10: tgt = int'(mdl[30][4:0]);
      default: tgt = -1;
    endcase
    @(negedge clk);
    wr_en = 1'b0;
    if (tgt >= 0) mdl[tgt] = d;
  endtask

  task automatic sweep(string req);
    for (int a = 0; a < 32; a++) begin
      for (int b = 0; b < 32; b++) begin
        rd_a_sel = 5'(a); rd_b_sel = 5'(b); #1;
        chk(req, {rd_a_data, rd_b_data}, {mdl[a], mdl[b]});
      end
    end
  endtask

  task automatic finish_run;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      finish_run();
    end
  end

  initial begin
    repeat (2) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    for (int i = 0; i < 32; i++) wr(2'b00, 5'(i), 8'hA5);
    // R1: synchronous clear
    @(negedge clk) rst = 1'b1;
    @(negedge clk) rst = 1'b0;
    for (int i = 0; i < 32; i++) mdl[i] = 8'h00;
    sweep("R1");
    chk("R1 ptr", ptr_out, 16'h0000);

    // R8/R2: direct writes of distinct values, then all operand pairs
    for (int i = 0; i < 32; i++) wr(2'b00, 5'(i), 8'((i * 37 + 5) & 255));
    sweep("R2 R8");

    // R4: immediate read field
    for (int k = 0; k < 16; k++) begin
      imm_sel = 4'(k); #1;
      chk("R4", {8'h00, imm_rd_data}, {8'h00, mdl[16 + k]});
    end

    // R3: immediate writes, bit 4 toggled, lower half untouched
    for (int k = 0; k < 16; k++)
      wr(2'b01, {1'(k & 1), 4'(k)}, 8'((k * 29 + 200) & 255));
    sweep("R3");

    // R9: old value visible while write is pending
    @(negedge clk);
    wr_en = 1'b1; wr_src = 2'b00; wr_sel = 5'd4; wr_data = ~mdl[4];
    rd_a_sel = 5'd4; #1;
    chk("R9", {8'h00, rd_a_data}, {8'h00, mdl[4]});
    @(negedge clk);
    wr_en = 1'b0; mdl[4] = ~mdl[4];
    chk("R9 after edge", {8'h00, rd_a_data}, {8'h00, mdl[4]});

    // R8: disabled write and source 11 change nothing
    @(negedge clk);
    wr_en = 1'b0; wr_src = 2'b00; wr_sel = 5'd7; wr_data = ~mdl[7];
    @(negedge clk);
    wr(2'b11, 5'd8, ~mdl[8]);
    sweep("R8 no write");

    // R5/R6: pointer and indirect read with junk in upper bits and r31
    for (int t = 0; t < 32; t++) begin
      wr(2'b00, 5'd30, {3'b101, 5'(t)});
      wr(2'b00, 5'd31, 8'((t * 11) & 255));
      #1;
      chk("R5", ptr_out, {mdl[31], mdl[30]});
      chk("R6", {8'h00, ind_rd_data}, {8'h00, mdl[mdl[30][4:0]]});
    end
    wr(2'b00, 5'd30, 8'hE5);
    for (int v = 0; v < 8; v++) begin
      wr(2'b00, 5'd31, 8'(v * 33));
      #1;
      chk("R6 r31 ignored", {8'h00, ind_rd_data}, {8'h00, mdl[5]});
    end

    // R7: indirect writes, including r30 naming itself
    wr(2'b00, 5'd30, 8'h69);
    wr(2'b10, 5'd0, 8'h5A);
    sweep("R7");
    wr(2'b00, 5'd30, 8'h1E);
    wr(2'b10, 5'd2, 8'h03);
    #1;
    chk("R7 self", ptr_out, {mdl[31], 8'h03});
    sweep("R7 self");

    done = 1;
    finish_run();
  end
endmodule